// File: doc/BRIEF.md
# Branch Resolution Unit

This block settles one branch per issue. From the address of the branch and its decoded fields, it decides whether control transfers and produces the address to fetch next. It also produces the values to write back to the link and counter registers. Two instruction shapes are accepted. The long shape carries a 24-bit word displacement and always transfers. The short shape carries a 14-bit word displacement and transfers only when its tests pass.

Each displacement is a count of 4-byte words. It is shifted left by two, then sign-extended to the full address width. A mode bit chooses how that offset is used: it is the target on its own (absolute), or it is added to the branch address (relative). The short shape tests one bit of a 32-bit condition word, chosen by a 5-bit index, against an option field. It can also decrement the loop counter and require the new value to be non-zero. Results are registered and appear one cycle after the issue strobe.

Top module: `branchResolve`

## Requirements
- R1: `resValid` is 1 exactly in the cycle after a cycle with `issueValid` = 1. All results appear in that cycle.
- R2: For the long shape (`isLong` = 1), `taken` is 1. `nextAddr` is the offset `signext(dispLong << 2)` when `absMode` = 1, and `instAddr` plus that offset when `absMode` = 0, wrapping modulo 2^32.
- R3: For the short shape (`isLong` = 0), a taken branch targets `signext(dispShort << 2)` when `absMode` = 1, and `instAddr` plus that offset when `absMode` = 0.
- R4: The condition test of the short shape passes when `optField[0]` = 1. It also passes when bit `biSel` of `condReg` (bit 0 is the LSB) equals `optField[1]`.
- R5: Counter handling in the short shape depends on `optField[2]`. When `optField[2]` = 0, `ctrWe` = 1, `ctrData` = `countIn` − 1 (wrapping), and the count test passes only if that decremented value is non-zero. When `optField[2]` = 1, `ctrWe` = 0 and the count test passes.
- R6: A short-shape branch is taken only when both the count test and the condition test pass. When it is not taken, `nextAddr` = `instAddr` + 4.
- R7: When `linkMode` = 1, `linkWe` = 1 and `linkData` = `instAddr` + 4, whether or not the branch is taken. When `linkMode` = 0, `linkWe` = 0.
- R8: While `rstN` is low, and after its release until the first issue, `resValid`, `taken`, `linkWe` and `ctrWe` are 0.
- R9: In a cycle with `resValid` = 0, `taken`, `linkWe` and `ctrWe` are 0.
- R10: The long shape ignores `optField`, `biSel` and `countIn`: `ctrWe` is 0 and the branch is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A branch is presented this cycle |
| isLong | input | 1 | 1 = long unconditional shape, 0 = short conditional shape |
| instAddr | input | 32 | Address of the branch |
| dispLong | input | 24 | Word displacement of the long shape |
| dispShort | input | 14 | Word displacement of the short shape |
| optField | input | 3 | [0] force condition, [1] required bit value, [2] skip counter |
| biSel | input | 5 | Index of the tested condition bit |
| absMode | input | 1 | 1 = absolute target, 0 = relative target |
| linkMode | input | 1 | 1 = write the return address |
| condReg | input | 32 | Condition word |
| countIn | input | 32 | Current loop counter |
| resValid | output | 1 | Results valid |
| taken | output | 1 | Branch transfers control |
| nextAddr | output | 32 | Next fetch address |
| linkWe | output | 1 | Link register write strobe |
| linkData | output | 32 | Return address |
| ctrWe | output | 1 | Counter write strobe |
| ctrData | output | 32 | Decremented counter |

## Verification
The bench builds the block with its default widths: 32-bit addresses and counter, a 32-bit condition word with a 5-bit index, and 24-bit and 14-bit displacements. These values let it reach the sign bit of each displacement and wrap of the address sum past 2^32. They also let it reach the end bits 0 and 31 of the condition word, and a counter decremented from 1 to 0 and from 0 to all ones. Random issues mix both shapes, all option settings and idle gaps, and directed cases cover these edges.

// File: rtl/brPkg.sv
package brPkg;
  typedef struct packed {
    logic fire;
    logic useLong;
    logic useAbs;
    logic writeLink;
    logic writeCtr;
    logic takeBranch;
  } brStrobes_t;
endpackage

// File: rtl/brControl.sv
module brControl
  import brPkg::*;
#(
  parameter int CR_W = 32,
  localparam int BI_W = $clog2(CR_W)
) (
  input  logic            issueValid,
  input  logic            isLong,
  input  logic [2:0]      optField,
  input  logic [BI_W-1:0] biSel,
  input  logic            absMode,
  input  logic            linkMode,
  input  logic [CR_W-1:0] condReg,
  input  logic            decIsZero,
  output brStrobes_t      strobes
);
  logic condBit;
  logic condPass;
  logic countPass;
  logic useCounter;

  always_comb begin
    condBit    = condReg[biSel];
    condPass   = optField[0] | (condBit == optField[1]);
    useCounter = ~isLong & ~optField[2];
    countPass  = ~useCounter | ~decIsZero;

    strobes.fire       = issueValid;
    strobes.useLong    = isLong;
    strobes.useAbs     = absMode;
    strobes.writeLink  = issueValid & linkMode;
    strobes.writeCtr   = issueValid & useCounter;
    strobes.takeBranch = issueValid & (isLong | (condPass & countPass));
  end
endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CTR_W    = 32,
  parameter int LONG_W   = 24,
  parameter int SHORT_W  = 14,
  parameter int WORD_SHF = 2,
  localparam int LONG_PAD  = ADDR_W - LONG_W - WORD_SHF,
  localparam int SHORT_PAD = ADDR_W - SHORT_W - WORD_SHF
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobes_t        strobes,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [LONG_W-1:0] dispLong,
  input  logic [SHORT_W-1:0] dispShort,
  input  logic [CTR_W-1:0]  countIn,
  output logic              decIsZero,
  output logic              resValid,
  output logic              taken,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData,
  output logic              ctrWe,
  output logic [CTR_W-1:0]  ctrData
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHF;

  logic [ADDR_W-1:0] longOff;
  logic [ADDR_W-1:0] shortOff;
  logic [ADDR_W-1:0] offSel;
  logic [ADDR_W-1:0] baseSel;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] seqAddr;
  logic [CTR_W-1:0]  ctrDec;

  always_comb begin
    longOff  = {{LONG_PAD{dispLong[LONG_W-1]}}, dispLong, {WORD_SHF{1'b0}}};
    shortOff = {{SHORT_PAD{dispShort[SHORT_W-1]}}, dispShort, {WORD_SHF{1'b0}}};
    offSel   = strobes.useLong ? longOff : shortOff;
    baseSel  = strobes.useAbs ? '0 : instAddr;
    target   = baseSel + offSel;
    seqAddr  = instAddr + STEP;
    ctrDec   = countIn - CTR_W'(1);
    decIsZero = (ctrDec == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      taken    <= 1'b0;
      nextAddr <= '0;
      linkWe   <= 1'b0;
      linkData <= '0;
      ctrWe    <= 1'b0;
      ctrData  <= '0;
    end else begin
      resValid <= strobes.fire;
      taken    <= strobes.takeBranch;
      linkWe   <= strobes.writeLink;
      ctrWe    <= strobes.writeCtr;
      if (strobes.fire) begin
        nextAddr <= strobes.takeBranch ? target : seqAddr;
        linkData <= seqAddr;
        ctrData  <= ctrDec;
      end
    end
  end
endmodule

// File: rtl/branchResolve.sv
module branchResolve
  import brPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CTR_W   = 32,
  parameter int CR_W    = 32,
  parameter int LONG_W  = 24,
  parameter int SHORT_W = 14,
  localparam int BI_W   = $clog2(CR_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic               isLong,
  input  logic [ADDR_W-1:0]  instAddr,
  input  logic [LONG_W-1:0]  dispLong,
  input  logic [SHORT_W-1:0] dispShort,
  input  logic [2:0]         optField,
  input  logic [BI_W-1:0]    biSel,
  input  logic               absMode,
  input  logic               linkMode,
  input  logic [CR_W-1:0]    condReg,
  input  logic [CTR_W-1:0]   countIn,
  output logic               resValid,
  output logic               taken,
  output logic [ADDR_W-1:0]  nextAddr,
  output logic               linkWe,
  output logic [ADDR_W-1:0]  linkData,
  output logic               ctrWe,
  output logic [CTR_W-1:0]   ctrData
);
  brStrobes_t strobes;
  logic       decIsZero;

  brControl #(.CR_W(CR_W)) ctrl (
    .issueValid(issueValid),
    .isLong(isLong),
    .optField(optField),
    .biSel(biSel),
    .absMode(absMode),
    .linkMode(linkMode),
    .condReg(condReg),
    .decIsZero(decIsZero),
    .strobes(strobes)
  );

  brDatapath #(
    .ADDR_W(ADDR_W), .CTR_W(CTR_W), .LONG_W(LONG_W), .SHORT_W(SHORT_W), .WORD_SHF(2)
  ) dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .instAddr(instAddr),
    .dispLong(dispLong),
    .dispShort(dispShort),
    .countIn(countIn),
    .decIsZero(decIsZero),
    .resValid(resValid),
    .taken(taken),
    .nextAddr(nextAddr),
    .linkWe(linkWe),
    .linkData(linkData),
    .ctrWe(ctrWe),
    .ctrData(ctrData)
  );
endmodule

// File: rtl/brCheck.sv
module brCheck #(
  parameter int ADDR_W = 32,
  parameter int CTR_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic              isLong,
  input logic [ADDR_W-1:0] instAddr,
  input logic              linkMode,
  input logic              resValid,
  input logic              taken,
  input logic              linkWe,
  input logic [ADDR_W-1:0] linkData,
  input logic              ctrWe,
  input logic [CTR_W-1:0]  ctrData,
  input logic [CTR_W-1:0]  countIn
);
  p_issue_to_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> resValid);
  p_idle_to_invalid_r1: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> !resValid);
  p_long_taken_r2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && isLong) |=> taken);
  p_link_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> (linkWe == $past(linkMode)));
  p_link_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (linkData == $past(instAddr) + ADDR_W'(4)));
  p_ctr_value_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrWe |-> (ctrData == $past(countIn) - CTR_W'(1)));
  p_long_no_ctr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && isLong) |=> !ctrWe);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!taken && !linkWe && !ctrWe));
endmodule

bind branchResolve brCheck #(.ADDR_W(ADDR_W), .CTR_W(CTR_W)) chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .isLong(isLong),
  .instAddr(instAddr), .linkMode(linkMode), .resValid(resValid), .taken(taken),
  .linkWe(linkWe), .linkData(linkData), .ctrWe(ctrWe), .ctrData(ctrData),
  .countIn(countIn)
);

// File: tb/branchResolve_test.sv
module branchResolve_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic        isLong = 1'b0;
  logic [31:0] instAddr = '0;
  logic [23:0] dispLong = '0;
  logic [13:0] dispShort = '0;
  logic [2:0]  optField = '0;
  logic [4:0]  biSel = '0;
  logic        absMode = 1'b0;
  logic        linkMode = 1'b0;
  logic [31:0] condReg = '0;
  logic [31:0] countIn = '0;
  logic        resValid, taken, linkWe, ctrWe;
  logic [31:0] nextAddr, linkData, ctrData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  branchResolve uut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] offLong(logic [23:0] d);
    return {{6{d[23]}}, d, 2'b00};
  endfunction
  function automatic logic [31:0] offShort(logic [13:0] d);
    return {{16{d[13]}}, d, 2'b00};
  endfunction

  task automatic issueAndCheck(logic lng, logic [31:0] a, logic [23:0] dl, logic [13:0] ds,
                               logic [2:0] opt, logic [4:0] bi, logic ab, logic lk,
                               logic [31:0] cr, logic [31:0] cnt);
    logic [31:0] tgt, dec;
    logic condOk, cntOk, expTaken, useCnt;
    issueValid = 1'b1; isLong = lng; instAddr = a; dispLong = dl; dispShort = ds;
    optField = opt; biSel = bi; absMode = ab; linkMode = lk; condReg = cr; countIn = cnt;
    tgt = (ab ? 32'd0 : a) + (lng ? offLong(dl) : offShort(ds));
    dec = cnt - 32'd1;
    condOk = opt[0] | (cr[bi] == opt[1]);
    useCnt = ~lng & ~opt[2];
    cntOk  = ~useCnt | (dec != 32'd0);
    expTaken = lng | (condOk & cntOk);
    @(posedge clk); @(negedge clk);
    check("R1 resValid", 32'(resValid), 32'd1);
    check(lng ? "R2/R10 taken" : "R4/R5/R6 taken", 32'(taken), 32'(expTaken));
    check(expTaken ? (lng ? "R2 nextAddr" : "R3 nextAddr") : "R6 nextAddr",
          nextAddr, expTaken ? tgt : a + 32'd4);
    check("R7 linkWe", 32'(linkWe), 32'(lk));
    if (lk) check("R7 linkData", linkData, a + 32'd4);
    check(lng ? "R10 ctrWe" : "R5 ctrWe", 32'(ctrWe), 32'(useCnt));
    if (useCnt) check("R5 ctrData", ctrData, dec);
  endtask

  task automatic idleCheck();
    issueValid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 resValid", 32'(resValid), 32'd0);
    check("R9 taken", 32'(taken), 32'd0);
    check("R9 linkWe", 32'(linkWe), 32'd0);
    check("R9 ctrWe", 32'(ctrWe), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R8 resValid", 32'(resValid), 32'd0);
    check("R8 taken", 32'(taken), 32'd0);
    check("R8 linkWe", 32'(linkWe), 32'd0);
    check("R8 ctrWe", 32'(ctrWe), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 idle after release", 32'(resValid | taken | linkWe | ctrWe), 32'd0);

    // R2 relative, negative displacement; R2 absolute with sign; address wrap
    issueAndCheck(1, 32'h0000_1000, 24'hFF_FFFC, 14'h0, 3'b000, 5'd0, 0, 1, 32'h0, 32'h5);
    issueAndCheck(1, 32'h0000_1000, 24'h80_0000, 14'h0, 3'b000, 5'd0, 1, 0, 32'h0, 32'h5);
    issueAndCheck(1, 32'hFFFF_FFF0, 24'h00_0010, 14'h0, 3'b010, 5'd3, 0, 0, 32'h0, 32'h1);
    // R3/R4 forced condition, absolute negative short
    issueAndCheck(0, 32'h0000_4000, 24'h0, 14'h2000, 3'b101, 5'd7, 1, 0, 32'h0, 32'h0);
    // R4 bit 31 match and mismatch, bit 0
    issueAndCheck(0, 32'h0000_4000, 24'h0, 14'h0010, 3'b110, 5'd31, 0, 0, 32'h8000_0000, 32'h0);
    issueAndCheck(0, 32'h0000_4000, 24'h0, 14'h0010, 3'b110, 5'd31, 0, 1, 32'h7FFF_FFFF, 32'h0);
    issueAndCheck(0, 32'h0000_4000, 24'h0, 14'h3FFF, 3'b100, 5'd0, 0, 0, 32'hFFFF_FFFE, 32'h0);
    // R5 counter 1 -> 0 not taken, 0 -> all ones taken
    issueAndCheck(0, 32'h0000_8000, 24'h0, 14'h0040, 3'b001, 5'd0, 0, 1, 32'h0, 32'h1);
    issueAndCheck(0, 32'h0000_8000, 24'h0, 14'h0040, 3'b001, 5'd0, 0, 0, 32'h0, 32'h0);
    // R6 counter passes, condition fails
    issueAndCheck(0, 32'h0000_8000, 24'h0, 14'h0040, 3'b000, 5'd2, 0, 0, 32'h4, 32'h9);
    idleCheck();

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 4) == 0) idleCheck();
      else issueAndCheck(1'($urandom), $urandom, 24'($urandom), 14'($urandom),
                         3'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
                         $urandom, 32'($urandom_range(0, 3)));
    end
    idleCheck();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule